// File: doc/BRIEF.md
# Escaped Frame Byte Encoder

This block turns a message, fed in one byte at a time, into a framed byte stream for the transmit FIFO of a debug communication port. Each frame begins with an opening flag that the caller picks when it starts the frame: one value for a normal message and another for an identification answer. The payload bytes follow, and a closing flag ends the frame. Some payload bytes fall inside the reserved flag range. Each of these is replaced by an escape flag and then by the original byte with its top bit flipped. The receiver can therefore never mistake payload for framing.

Every output byte leaves the block as a 32-bit transmit word. The byte sits in the low lane and the upper lanes are filled with the NULL flag. Before each word is written, the block polls a status word from the port. It waits while the port reports no free space. It stops at once on a link error or an overflow. It gives up after a fixed number of polls that all show no space. At the end of a frame, the block pulses `done_o` together with a result code and the number of words it wrote.

Top module: `frame_tx_encoder`

## Requirements
- R1: While reset is held and right after it, `wr_o`, `done_o`, `in_ready_o` and `busy_o` are 0 and `count_o` is 0.
- R2: A pulse on `start_i` while idle starts a frame. The first word written carries 0xAC when `open_sel_i` is 0 and 0xA1 when it is 1.
- R3: A payload byte whose top three bits are 101 (0xA0 to 0xBF) is written as two words: the escape flag 0xAE, then the byte XOR 0x80.
- R4: Any other payload byte, including the edge values 0x9F and 0xC0, is written once and unchanged, in input order.
- R5: After the payload byte marked by `in_last_i`, the closing flag 0xAD is written. One cycle later `done_o` pulses for one cycle with `result_o` = 0 (success) and `count_o` equal to the number of words written in the frame.
- R6: Each word has the output byte in bits [7:0] and 0xAF in each of bits [15:8], [23:16] and [31:24].
- R7: A word is written only at a clock edge where `stat_i[7:0]` (free space) is non-zero and neither error bit is set. While free space reads zero, nothing is written.
- R8: If `stat_i[14]` (link error) is set at a poll, the frame aborts with `result_o` = 2 (disconnect) and nothing more is written. This check wins over the overflow check.
- R9: If `stat_i[13]` (overflow) is set at a poll and the link error bit is clear, the frame aborts with `result_o` = 3 (fail).
- R10: If free space reads zero for 50000 polls in a row (one poll per cycle while a byte is pending), the frame aborts with `result_o` = 1 (timeout). After 49999 such polls, a non-zero reading still lets the write go ahead.
- R11: `in_ready_o` is high only while the block waits for the next payload byte, and each handshake takes exactly one byte. A `start_i` pulse while `busy_o` is high has no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a frame when idle |
| open_sel_i | input | 1 | Opening flag select: 0 normal (0xAC), 1 identification (0xA1) |
| in_data_i | input | 8 | Payload byte |
| in_valid_i | input | 1 | Payload byte valid |
| in_last_i | input | 1 | Marks the final payload byte |
| in_ready_o | output | 1 | Block accepts a payload byte |
| stat_i | input | 32 | Port status: [7:0] free space, [13] overflow, [14] link error |
| wr_o | output | 1 | Transmit word write strobe |
| wr_data_o | output | 32 | Transmit word |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle frame completion pulse |
| result_o | output | 2 | 0 success, 1 timeout, 2 disconnect, 3 fail |
| count_o | output | 11 | Words written in the last frame |

## Verification
The hardest case to reach from the ports is the edge of the poll limit. A timeout must happen on exactly the 50000th poll in a row that shows no space, and a write must still happen when space shows up on the 49999th poll. The stimulus holds free space at zero from the start pulse, counts clock edges from the edge that takes the start, and releases the space one edge before the limit in one run and never in the other. Errors in the middle of a frame are reached by raising the link error bit after the opening flag is written, while the block waits for payload. The abort then lands on the poll for the first payload byte.

// File: rtl/frame_enc_pkg.sv
package frame_enc_pkg;
  localparam logic [7:0] FLG_NORMAL = 8'hAC;
  localparam logic [7:0] FLG_IDENT  = 8'hA1;
  localparam logic [7:0] FLG_CLOSE  = 8'hAD;
  localparam logic [7:0] FLG_ESC    = 8'hAE;
  localparam logic [7:0] FLG_NULL   = 8'hAF;
  localparam logic [2:0] RSV_TOP    = 3'b101;
  localparam logic [7:0] ESC_FLIP   = 8'h80;

  typedef enum logic [1:0] {
    RES_OK         = 2'd0,
    RES_TIMEOUT    = 2'd1,
    RES_DISCONNECT = 2'd2,
    RES_FAIL       = 2'd3
  } res_e;

  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_FETCH, ST_DONE} st_e;
  typedef enum logic [1:0] {PH_OPEN, PH_DATA, PH_ESC, PH_CLOSE} ph_e;
endpackage

// File: rtl/fenc_escape.sv
module fenc_escape
  import frame_enc_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       need_esc_o,
  output logic [7:0] first_o,
  output logic [7:0] second_o
);
  always_comb begin
    need_esc_o = (byte_i[7:5] == RSV_TOP);
    first_o    = need_esc_o ? FLG_ESC : byte_i;
    second_o   = byte_i ^ ESC_FLIP;
  end
endmodule

// File: rtl/fenc_pacer.sv
module fenc_pacer
  import frame_enc_pkg::*;
#(
  parameter int STAT_W     = 32,
  parameter int SPACE_W    = 8,
  parameter int OVF_BIT    = 13,
  parameter int LINK_BIT   = 14,
  parameter int POLL_LIMIT = 50000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_en_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              go_o,
  output logic              abort_o,
  output res_e              code_o
);
  localparam int PC_W = $clog2(POLL_LIMIT + 1);

  logic [PC_W-1:0] poll_q;
  logic link, ovf, space, starved, expired;

  always_comb begin
    link    = stat_i[LINK_BIT];
    ovf     = stat_i[OVF_BIT];
    space   = |stat_i[SPACE_W-1:0];
    starved = !link && !ovf && !space;
    expired = starved && (poll_q == PC_W'(POLL_LIMIT - 1));
    go_o    = poll_en_i && !link && !ovf && space;
    abort_o = poll_en_i && (link || ovf || expired);
    // link error outranks overflow
    code_o  = link ? RES_DISCONNECT : (ovf ? RES_FAIL : RES_TIMEOUT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     poll_q <= '0;
    else if (!poll_en_i || !starved) poll_q <= '0;
    else                             poll_q <= poll_q + 1'b1;
  end

  assert_poll_bounded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_q <= PC_W'(POLL_LIMIT));
endmodule

// File: rtl/frame_tx_encoder.sv
module frame_tx_encoder
  import frame_enc_pkg::*;
#(
  parameter int MAX_PAYLOAD = 512,
  parameter int POLL_LIMIT  = 50000,
  parameter int WORD_BYTES  = 4,
  parameter int STAT_W      = 32,
  parameter int SPACE_W     = 8,
  parameter int OVF_BIT     = 13,
  parameter int LINK_BIT    = 14,
  localparam int WORD_W     = 8 * WORD_BYTES,
  localparam int CNT_W      = $clog2(2 * MAX_PAYLOAD + 3)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              open_sel_i,
  input  logic [7:0]        in_data_i,
  input  logic              in_valid_i,
  input  logic              in_last_i,
  output logic              in_ready_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic              wr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [1:0]        result_o,
  output logic [CNT_W-1:0]  count_o
);
  st_e        state_q;
  ph_e        phase_q;
  logic [7:0] cur_q, held_q;
  logic       last_q;
  res_e       res_q;
  logic [CNT_W-1:0] cnt_q;

  logic       esc_need;
  logic [7:0] esc_first, esc_second;
  logic       pace_go, pace_abort;
  res_e       pace_code;
  logic [WORD_W-1:0] word_next;

  fenc_escape u_esc (
    .byte_i     (in_data_i),
    .need_esc_o (esc_need),
    .first_o    (esc_first),
    .second_o   (esc_second)
  );

  fenc_pacer #(
    .STAT_W     (STAT_W),
    .SPACE_W    (SPACE_W),
    .OVF_BIT    (OVF_BIT),
    .LINK_BIT   (LINK_BIT),
    .POLL_LIMIT (POLL_LIMIT)
  ) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .poll_en_i (state_q == ST_SEND),
    .stat_i    (stat_i),
    .go_o      (pace_go),
    .abort_o   (pace_abort),
    .code_o    (pace_code)
  );

  assign word_next[7:0] = cur_q;
  for (genvar g = 1; g < WORD_BYTES; g++) begin : g_pad
    assign word_next[8*g +: 8] = FLG_NULL;
  end

  assign in_ready_o = (state_q == ST_FETCH);
  assign busy_o     = (state_q != ST_IDLE);
  assign result_o   = res_q;
  assign count_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_OPEN;
      cur_q     <= '0;
      held_q    <= '0;
      last_q    <= 1'b0;
      res_q     <= RES_OK;
      cnt_q     <= '0;
      wr_o      <= 1'b0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      wr_o   <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q   <= open_sel_i ? FLG_IDENT : FLG_NORMAL;
          phase_q <= PH_OPEN;
          last_q  <= 1'b0;
          cnt_q   <= '0;
          state_q <= ST_SEND;
        end
        ST_SEND: begin
          if (pace_abort) begin
            res_q   <= pace_code;
            state_q <= ST_DONE;
          end else if (pace_go) begin
            wr_o      <= 1'b1;
            wr_data_o <= word_next;
            cnt_q     <= cnt_q + 1'b1;
            unique case (phase_q)
              PH_OPEN: state_q <= ST_FETCH;
              PH_ESC: begin
                cur_q   <= held_q;
                phase_q <= PH_DATA;
              end
              PH_DATA: begin
                if (last_q) begin
                  cur_q   <= FLG_CLOSE;
                  phase_q <= PH_CLOSE;
                end else begin
                  state_q <= ST_FETCH;
                end
              end
              PH_CLOSE: begin
                res_q   <= RES_OK;
                state_q <= ST_DONE;
              end
            endcase
          end
        end
        ST_FETCH: if (in_valid_i) begin
          last_q  <= in_last_i;
          held_q  <= esc_second;
          cur_q   <= esc_first;
          phase_q <= esc_need ? PH_ESC : PH_DATA;
          state_q <= ST_SEND;
        end
        ST_DONE: begin
          done_o  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_write_needs_space_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> ($past(stat_i[SPACE_W-1:0]) != '0));
  assert_link_blocks_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !$past(stat_i[LINK_BIT]));
  assert_ovf_blocks_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> !$past(stat_i[OVF_BIT]));
  assert_done_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_pad_lanes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (wr_data_o[WORD_W-1:8] == {(WORD_BYTES-1){FLG_NULL}}));
  assert_timeout_starved_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && res_q == RES_TIMEOUT) |-> ($past(stat_i[SPACE_W-1:0], 2) == '0));
  assert_ready_no_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> !busy_o == 1'b0);
endmodule

// File: tb/frame_tx_encoder_tb.sv
module frame_tx_encoder_tb;
  import frame_enc_pkg::*;

  localparam logic [31:0] FREE = 32'h0000_0001;
  localparam logic [31:0] OVF  = 32'h0000_2000;
  localparam logic [31:0] LINK = 32'h0000_4000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        start_i, open_sel_i, in_valid_i, in_last_i;
  logic [7:0]  in_data_i;
  logic [31:0] stat_i;
  logic        in_ready_o, wr_o, busy_o, done_o;
  logic [31:0] wr_data_o;
  logic [1:0]  result_o;
  logic [10:0] count_o;

  always #10 clk = ~clk;

  frame_tx_encoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .open_sel_i(open_sel_i),
    .in_data_i(in_data_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
    .in_ready_o(in_ready_o), .stat_i(stat_i), .wr_o(wr_o), .wr_data_o(wr_data_o),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .count_o(count_o)
  );

  int n_cmp = 0, n_bad = 0;
  logic [7:0]  exp_q[$];
  logic [1:0]  exp_res;
  int          exp_cnt;
  string       cur_req = "R1";
  logic [31:0] stat_at_edge = '0;

  always @(posedge clk) stat_at_edge <= stat_i;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write, checks the outcome on done
  always @(negedge clk) begin : mon
    logic [7:0] e;
    if (rst_ni) begin
      if (wr_o) begin
        chk(stat_at_edge[7:0] != 0 && !stat_at_edge[14] && !stat_at_edge[13],
            "R7", "write without clear space", stat_at_edge, FREE);
        chk(wr_data_o[31:8] == 24'hAFAFAF, "R6", "pad lanes", wr_data_o[31:8], 24'hAFAFAF);
        if (exp_q.size() == 0) chk(0, cur_req, "unexpected write", wr_data_o[7:0], 0);
        else begin
          e = exp_q.pop_front();
          chk(wr_data_o[7:0] == e, cur_req, "byte", wr_data_o[7:0], e);
        end
      end
      if (done_o) begin
        chk(result_o == exp_res, cur_req, "result", result_o, exp_res);
        chk(count_o == 11'(exp_cnt), "R5", "count", count_o, exp_cnt);
        chk(exp_q.size() == 0, cur_req, "missing bytes", exp_q.size(), 0);
      end
    end
  end

  task automatic start_frame(bit sel);
    @(negedge clk);
    open_sel_i = sel;
    start_i    = 1'b1;
    @(negedge clk);
    start_i    = 1'b0;
  endtask

  task automatic feed(logic [7:0] b, bit last);
    in_data_i  = b;
    in_last_i  = last;
    in_valid_i = 1'b1;
    while (!in_ready_o) @(negedge clk);
    @(negedge clk);
    in_valid_i = 1'b0;
    in_last_i  = 1'b0;
  endtask

  task automatic wait_done();
    while (!done_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_frame(bit sel, logic [7:0] pay[$]);
    exp_q.push_back(sel ? 8'hA1 : 8'hAC);
    foreach (pay[i]) begin
      if (pay[i][7:5] == 3'b101) begin
        exp_q.push_back(8'hAE);
        exp_q.push_back(pay[i] ^ 8'h80);
      end else exp_q.push_back(pay[i]);
    end
    exp_q.push_back(8'hAD);
    exp_cnt = exp_q.size();
    exp_res = 2'd0;
  endtask

  task automatic run_msg(string req, bit sel, logic [7:0] pay[$]);
    cur_req = req;
    expect_frame(sel, pay);
    start_frame(sel);
    foreach (pay[i]) feed(pay[i], i == pay.size() - 1);
    wait_done();
  endtask

  task automatic run_abort(string req, logic [31:0] st, logic [1:0] res);
    cur_req = req;
    exp_cnt = 0;
    exp_res = res;
    stat_i  = st;
    start_frame(1'b0);
    wait_done();
    stat_i  = FREE;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : drive
    rst_ni = 1'b0; start_i = 1'b0; open_sel_i = 1'b0;
    in_valid_i = 1'b0; in_last_i = 1'b0; in_data_i = '0; stat_i = FREE;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(!wr_o && !done_o && !in_ready_o && !busy_o, "R1", "outputs in reset",
        {wr_o, done_o, in_ready_o, busy_o}, 0);
    chk(count_o == 0, "R1", "count in reset", count_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!wr_o && !done_o && !in_ready_o && !busy_o, "R1", "outputs after reset",
        {wr_o, done_o, in_ready_o, busy_o}, 0);

    // R2 normal opening, plain payload (R4)
    run_msg("R2", 1'b0, '{8'h01, 8'h02, 8'h03});
    // R2 identification opening, escape edges R3 and plain edges R4
    run_msg("R3/R4", 1'b1, '{8'hA0, 8'hBF, 8'h9F, 8'hC0, 8'hAE, 8'h00});
    run_msg("R3", 1'b0, '{8'hAD, 8'hAF, 8'hFF, 8'h7F});

    // R7 stall with zero space mid-frame, R11 start pulse while busy is ignored
    fork
      run_msg("R11", 1'b0, '{8'h10, 8'hB5, 8'h20, 8'h30});
      begin
        repeat (3) @(negedge clk);
        stat_i = '0;
        repeat (5) @(negedge clk);
        chk(busy_o && !wr_o, "R7", "stall while no space", {busy_o, wr_o}, 2);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
        stat_i = FREE;
      end
    join

    // R8 link error at the first poll, also with overflow set (priority)
    run_abort("R8", LINK | FREE, 2'd2);
    run_abort("R8", LINK | OVF | FREE, 2'd2);
    // R9 overflow only
    run_abort("R9", OVF | FREE, 2'd3);

    // R8 link error in the middle of a frame, after the opening flag
    cur_req = "R8";
    exp_q.push_back(8'hAC);
    exp_cnt = 1;
    exp_res = 2'd2;
    start_frame(1'b0);
    @(negedge clk);
    stat_i = LINK | FREE;
    feed(8'h11, 1'b1);
    wait_done();
    stat_i = FREE;
    chk(!in_ready_o && !busy_o, "R11", "idle after abort", {in_ready_o, busy_o}, 0);

    // R10 timeout on the 50000th starved poll
    run_abort("R10", 32'h0, 2'd1);

    // R10 space arriving on poll 50000 after 49999 starved polls
    cur_req = "R10";
    exp_q.push_back(8'hAC);
    exp_q.push_back(8'h55);
    exp_q.push_back(8'hAD);
    exp_cnt = 3;
    exp_res = 2'd0;
    stat_i  = '0;
    start_frame(1'b0);
    repeat (49999) @(posedge clk);
    @(negedge clk);
    stat_i = FREE;
    feed(8'h55, 1'b1);
    wait_done();

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule